// File: doc/BRIEF.md
# Flash Identification and Sector-Protect Unit

This block holds the identification and write-protection logic of a byte-wide flash device. The device has a 19-bit address space in eight sectors of 64 KiB. When identification mode is selected, the low address bits choose what appears on an 8-bit read port. The choices are a fixed vendor code, a fixed device code, or the protection state of the sector named by the top three address bits.

Protection is stored as one bit per sector. A bit can only be set by a qualified write-enable pulse. That pulse counts only while two high-voltage indicator flags are raised and chip enable is inactive. Program and erase logic elsewhere asks the unit whether a target sector may be changed, through a per-sector block output.

All pin-level inputs cross into the system clock domain through two-stage synchronizers before any decision is made.

Top module: `flash_idprot_unit`

## Requirements
- R1: In identification mode, with address bits [1:0] = 2'b00, the read port shows 0x04 and the valid output is high.
- R2: In identification mode, with address bits [1:0] = 2'b01, the read port shows 0xA4 and the valid output is high.
- R3: In identification mode, with address bits [1:0] = 2'b10, the read port shows 0x01 if the sector selected by address bits [18:16] is protected and 0x00 otherwise, with valid high.
- R4: With address bits [1:0] = 2'b11, or when identification mode is off, the read port is 0x00 and valid is low.
- R5: After reset all eight sectors are unprotected.
- R6: When both high-voltage flags are high and active-low chip enable is high, a write-enable low pulse followed by its return high sets the protection bit of the sector given by address bits [18:16] when the pulse ends. No other bit changes.
- R7: A write-enable pulse while either high-voltage flag is low, or while chip enable is active (low), sets no bit and raises no error.
- R8: If address bits [18:16] change during a qualified pulse, or qualification drops before it ends, no bit is set and the error output pulses high for one cycle.
- R9: Protection bits only accumulate. Any subset of sectors, from none to all eight, can be protected, and later protections leave earlier ones in place.
- R10: The block output is high in the same cycle exactly when the sector given on the program/erase sector input is protected.
- R11: Read results follow an address or mode change after two rising clock edges. A protection bit is set on the third rising edge after write enable returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 19 | Device address pins |
| id_mode_i | input | 1 | Identification mode select |
| hv_addr_i | input | 1 | High-voltage indicator on the address path |
| hv_oe_i | input | 1 | High-voltage indicator on the output-enable path |
| chip_en_ni | input | 1 | Chip enable, active low |
| wr_en_ni | input | 1 | Write enable, active low |
| pe_sector_i | input | 3 | Sector targeted by a program/erase request |
| rd_data_o | output | 8 | Identification read data |
| rd_valid_o | output | 1 | Read data valid |
| prot_o | output | 8 | Protection bit per sector |
| pe_block_o | output | 1 | Program/erase inhibit for pe_sector_i |
| prot_err_o | output | 1 | One-cycle pulse when a protect pulse is rejected |

## Verification
Read results are due on the second rising edge after the bench changes address or mode. Each read task therefore waits three cycles and samples on a falling edge. One test samples after the first and after the second edge, to check that the value changes exactly at the second. A protection bit is due on the third edge after write enable rises; that test checks the block output is still low after two edges and high after three. The other protect tasks wait five cycles before reading. Error pulses last one cycle, so a bench counter catches them at every rising edge, and each task compares the count before and after its pulse.

// File: rtl/flash_idprot_pkg.sv
package flash_idprot_pkg;
  localparam logic [7:0] VENDOR_CODE = 8'h04;
  localparam logic [7:0] DEVICE_CODE = 8'hA4;

  typedef enum logic [1:0] {
    SEL_VENDOR = 2'b00,
    SEL_DEVICE = 2'b01,
    SEL_PROT   = 2'b10,
    SEL_NONE   = 2'b11
  } id_sel_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/prot_seq.sv
module prot_seq #(
  parameter int unsigned SECT_W = 3,
  localparam int unsigned NSECT = 1 << SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              armed_i,
  input  logic              we_n_i,
  input  logic [SECT_W-1:0] sect_i,
  output logic [NSECT-1:0]  prot_o,
  output logic              err_o
);
  logic              we_d_q, active_q, bad_q;
  logic [SECT_W-1:0] sect_q;
  logic              fall, rise;

  assign fall = we_d_q & ~we_n_i;
  assign rise = ~we_d_q & we_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_d_q   <= 1'b1;
      active_q <= 1'b0;
      bad_q    <= 1'b0;
      sect_q   <= '0;
      prot_o   <= '0;
      err_o    <= 1'b0;
    end else begin
      we_d_q <= we_n_i;
      err_o  <= 1'b0;
      if (fall) begin
        // only a qualified falling edge opens a protect window
        active_q <= armed_i;
        bad_q    <= 1'b0;
        sect_q   <= sect_i;
      end else if (active_q) begin
        if (rise) begin
          active_q <= 1'b0;
          if (!bad_q && armed_i && sect_i == sect_q) prot_o[sect_q] <= 1'b1;
          else err_o <= 1'b1;
        end else if (!armed_i || sect_i != sect_q) begin
          bad_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/id_read_mux.sv
module id_read_mux
  import flash_idprot_pkg::*;
(
  input  logic       id_mode_i,
  input  logic [1:0] sel_i,
  input  logic       prot_bit_i,
  output logic [7:0] data_o,
  output logic       valid_o
);
  always_comb begin
    data_o  = 8'h00;
    valid_o = 1'b0;
    if (id_mode_i) begin
      valid_o = 1'b1;
      unique case (id_sel_e'(sel_i))
        SEL_VENDOR: data_o = VENDOR_CODE;
        SEL_DEVICE: data_o = DEVICE_CODE;
        SEL_PROT:   data_o = {7'd0, prot_bit_i};
        default:    valid_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/flash_idprot_unit.sv
module flash_idprot_unit #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned SECT_W = 3,
  localparam int unsigned NSECT = 1 << SECT_W,
  localparam int unsigned SYNC_W = ADDR_W + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              id_mode_i,
  input  logic              hv_addr_i,
  input  logic              hv_oe_i,
  input  logic              chip_en_ni,
  input  logic              wr_en_ni,
  input  logic [SECT_W-1:0] pe_sector_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  output logic [NSECT-1:0]  prot_o,
  output logic              pe_block_o,
  output logic              prot_err_o
);
  // packing: {id_mode, hv_addr, hv_oe, chip_en_n, wr_en_n, addr}
  localparam logic [SYNC_W-1:0] SYNC_RST = {3'b000, 2'b11, {ADDR_W{1'b0}}};

  logic [SYNC_W-1:0] raw, syn;
  logic [ADDR_W-1:0] s_addr;
  logic              s_id_mode, s_hv_addr, s_hv_oe, s_ce_n, s_we_n;
  logic [SECT_W-1:0] s_sect;
  logic              armed;

  assign raw = {id_mode_i, hv_addr_i, hv_oe_i, chip_en_ni, wr_en_ni, addr_i};

  pin_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {s_id_mode, s_hv_addr, s_hv_oe, s_ce_n, s_we_n, s_addr} = syn;
  assign s_sect = s_addr[ADDR_W-1 -: SECT_W];
  assign armed  = s_hv_addr & s_hv_oe & s_ce_n;

  prot_seq #(.SECT_W(SECT_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .armed_i(armed),
    .we_n_i (s_we_n),
    .sect_i (s_sect),
    .prot_o (prot_o),
    .err_o  (prot_err_o)
  );

  id_read_mux u_mux (
    .id_mode_i (s_id_mode),
    .sel_i     (s_addr[1:0]),
    .prot_bit_i(prot_o[s_sect]),
    .data_o    (rd_data_o),
    .valid_o   (rd_valid_o)
  );

  assign pe_block_o = prot_o[pe_sector_i];
endmodule

module flash_idprot_checker #(
  parameter int unsigned NSECT = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NSECT-1:0] prot_i,
  input logic             err_i,
  input logic [7:0]       rd_data_i,
  input logic             rd_valid_i
);
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |-> rd_data_i == 8'h00); // R4
  AST_READ_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |-> (rd_data_i == 8'h04 || rd_data_i == 8'hA4 || rd_data_i <= 8'h01)); // R1
  AST_PROT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (prot_i & $past(prot_i)) == $past(prot_i)); // R9
  AST_ONE_BIT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(prot_i ^ $past(prot_i)) <= 1); // R6
  AST_ERR_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> $stable(prot_i)); // R8
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> !err_i); // R8
endmodule

bind flash_idprot_unit flash_idprot_checker #(.NSECT(NSECT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .prot_i    (prot_o),
  .err_i     (prot_err_o),
  .rd_data_i (rd_data_o),
  .rd_valid_i(rd_valid_o)
);

// File: tb/flash_idprot_unit_bench.sv
module flash_idprot_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] addr = '0;
  logic        id_mode = 1'b0, hv_a = 1'b0, hv_oe = 1'b0, ce_n = 1'b1, we_n = 1'b1;
  logic [2:0]  pe_sec = '0;
  logic [7:0]  rd_data, prot;
  logic        rd_valid, pe_block, perr;

  int checks = 0, fails = 0, err_cnt = 0;
  logic [7:0] model = '0;

  always #5 clk = ~clk;

  flash_idprot_unit u_flash_idprot_unit (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .id_mode_i(id_mode),
    .hv_addr_i(hv_a), .hv_oe_i(hv_oe), .chip_en_ni(ce_n), .wr_en_ni(we_n),
    .pe_sector_i(pe_sec), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .prot_o(prot), .pe_block_o(pe_block), .prot_err_o(perr)
  );

  always @(posedge clk) if (perr) err_cnt++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [2:0] sec, logic [1:0] sel);
    addr = {sec, 14'd0, sel};
    cyc(3);
  endtask

  task automatic pulse(logic [2:0] sec, bit arm_a, bit arm_o, bit ce_hi, bit move);
    id_mode = 1'b0;
    addr = {sec, 16'd0};
    hv_a = arm_a; hv_oe = arm_o; ce_n = ce_hi;
    cyc(3);
    we_n = 1'b0;
    cyc(4);
    if (move) begin addr = {sec + 3'd1, 16'd0}; cyc(3); end
    we_n = 1'b1;
    cyc(5);
    hv_a = 1'b0; hv_oe = 1'b0; ce_n = 1'b1;
    cyc(2);
  endtask

  task automatic t_reset();
    check("R5 reset mask", prot, 8'h00);
    check("R5 reset err", perr, 1'b0);
    id_mode = 1'b1;
    for (int s = 0; s < 8; s++) begin
      rd(s[2:0], 2'b10);
      check("R5 R3 unprotected read", rd_data, 8'h00);
    end
  endtask

  task automatic t_ids();
    id_mode = 1'b1;
    rd(3'd5, 2'b00);
    check("R1 vendor", rd_data, 8'h04);
    check("R1 valid", rd_valid, 1'b1);
    addr = {3'd2, 14'd0, 2'b01};
    cyc(1);
    check("R11 read not yet", rd_data, 8'h04);
    cyc(1);
    check("R11 R2 device", rd_data, 8'hA4);
    check("R2 valid", rd_valid, 1'b1);
  endtask

  task automatic t_idle();
    id_mode = 1'b1;
    rd(3'd0, 2'b11);
    check("R4 sel11 data", rd_data, 8'h00);
    check("R4 sel11 valid", rd_valid, 1'b0);
    id_mode = 1'b0;
    rd(3'd0, 2'b00);
    check("R4 mode off data", rd_data, 8'h00);
    check("R4 mode off valid", rd_valid, 1'b0);
  endtask

  task automatic t_protect_latency();
    pe_sec = 3'd3;
    id_mode = 1'b0;
    addr = {3'd3, 16'd0};
    hv_a = 1'b1; hv_oe = 1'b1; ce_n = 1'b1;
    cyc(3);
    we_n = 1'b0;
    cyc(4);
    we_n = 1'b1;
    cyc(2);
    check("R11 prot not yet", pe_block, 1'b0);
    cyc(1);
    check("R11 R6 prot set", pe_block, 1'b1);
    model[3] = 1'b1;
    cyc(2);
    hv_a = 1'b0; hv_oe = 1'b0;
    cyc(2);
    check("R6 only sector 3", prot, model);
  endtask

  task automatic t_unarmed();
    int e0 = err_cnt;
    pulse(3'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R7 no hv addr", prot, model);
    pulse(3'd1, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R7 no hv oe", prot, model);
    pulse(3'd1, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R7 ce active", prot, model);
    check("R7 no error", err_cnt, e0);
  endtask

  task automatic t_glitch();
    int e0 = err_cnt;
    pulse(3'd6, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R8 no bit", prot, model);
    check("R8 one error", err_cnt, e0 + 1);
  endtask

  task automatic t_multi();
    pulse(3'd0, 1'b1, 1'b1, 1'b1, 1'b0); model[0] = 1'b1;
    pulse(3'd5, 1'b1, 1'b1, 1'b1, 1'b0); model[5] = 1'b1;
    pulse(3'd7, 1'b1, 1'b1, 1'b1, 1'b0); model[7] = 1'b1;
    check("R9 accumulate", prot, model);
    id_mode = 1'b1;
    for (int s = 0; s < 8; s++) begin
      rd(s[2:0], 2'b10);
      check("R3 status read", rd_data, {7'd0, model[s]});
    end
    for (int s = 0; s < 8; s++) begin
      pe_sec = s[2:0];
      #1;
      check("R10 block", pe_block, model[s]);
    end
    for (int s = 0; s < 8; s++) begin
      if (!model[s]) begin
        pulse(s[2:0], 1'b1, 1'b1, 1'b1, 1'b0);
        model[s] = 1'b1;
      end
    end
    check("R9 all protected", prot, 8'hFF);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_ids();
    t_idle();
    t_protect_latency();
    t_unarmed();
    t_glitch();
    t_multi();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule